// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between an 8-bit sound processor and its memories. It turns every 16-bit processor address into a physical address. The target is either a 512 KB ROM or a 4 MB RAM. The result depends on three small registers that the processor loads through I/O writes: a main page, an extra page and a 6-bit configuration word.

The configuration word selects one of two maps. In ROM-visible mode, the lowest 16 KB quarter shows the start of ROM and the top half shows a 32 KB ROM page. In ROM-excluded mode, the lowest quarter and two upper 16 KB windows are all RAM. The second quarter always shows one fixed RAM page. An expanded-paging option gives each upper window its own page register. Low RAM can be write-protected.

The mapping is purely combinational from the address inputs, so a memory access sees its translated address in the same cycle. Register loads take effect on the next clock edge. Two configuration bits are also exported to the clock generator as a speed selection.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset the configuration word is 0x30 and the main page is 0. The extra page is also 0, so the ROM-visible map is active, `spd_base` is 1 and `spd_double` is 0.
- R2: In ROM-visible mode (configuration bit 0 clear), addresses 0x0000–0x3FFF select ROM with `rom_addr` equal to the address, in the first 16 KB of ROM.
- R3: Addresses 0x4000–0x7FFF select RAM at physical 0x4000 plus the offset within the quarter, in every mode.
- R4: In ROM-visible mode, addresses 0x8000–0xFFFF select ROM. `rom_addr` equals the main page modulo 16, times 0x8000, plus address bits 14:0.
- R5: In ROM-excluded mode (configuration bit 0 set), addresses 0x0000–0x3FFF select RAM at physical addresses 0x0000–0x3FFF.
- R6: In ROM-excluded mode with expanded paging (configuration bit 3) clear, the 0x8000 window uses RAM page ((main<<1)|0) mod 256. The 0xC000 window uses page ((main<<1)|1) mod 256. The physical address is page×0x4000 plus address bits 13:0.
- R7: In ROM-excluded mode with expanded paging set, the 0x8000 window uses page ((main<<1)|main[7]) mod 256. The 0xC000 window uses page ((extra<<1)|extra[7]) mod 256.
- R8: `ram_we` follows `cpu_wr` only when RAM is selected and the target is not protected. A write aimed at ROM never produces `ram_we`. `rom_rd` and `ram_rd` pass `cpu_rd` to the selected memory only.
- R9: With configuration bits 0 and 1 both set, writes to 0x0000–0x3FFF are suppressed and reads there still go to RAM. In ROM-visible mode, bit 1 has no effect.
- R10: An I/O write loads a register when the low address byte equals its port: 0x00 for the main page, 0x10 for the extra page, 0x0F for the configuration. The configuration keeps data bits 5:0 only. Writes to other ports change nothing.
- R11: `spd_base` equals configuration bit 5 and `spd_double` equals the inverse of configuration bit 4. Both are updated on the clock edge after a configuration write.
- R12: Port decode ignores I/O address bits 15:8, so any upper byte reaches the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor memory address |
| cpu_rd | input | 1 | Processor memory read strobe |
| cpu_wr | input | 1 | Processor memory write strobe |
| io_addr | input | 16 | Processor I/O address |
| io_wr | input | 1 | Processor I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| rom_sel | output | 1 | 1: access goes to ROM, 0: to RAM |
| rom_addr | output | 19 | Physical ROM byte address |
| ram_addr | output | 22 | Physical RAM byte address |
| rom_rd | output | 1 | Read strobe to ROM |
| ram_rd | output | 1 | Read strobe to RAM |
| ram_we | output | 1 | Write enable to RAM after protection |
| spd_base | output | 1 | Speed select: base clock family |
| spd_double | output | 1 | Speed select: doubled clock |

## Verification
On every cycle, the assertions check several properties. No write ever reaches RAM while ROM is selected or while protected low RAM is addressed. ROM-visible mode always maps the low quarter to the start of ROM. Each register changes only on a write to its own port, and takes that write's data. The speed pins follow the configuration write one cycle later. Only the bench's scenarios can show the page arithmetic itself: the shift-and-OR page numbers, their wrap modulo 256, and the ROM page wrap modulo 16. The bench also covers every window edge in each mode, and the upper-byte aliasing of the port decode.

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
  parameter int RAM_PAGE_W = 8,
  parameter int ROM_PAGE_W = 4,
  parameter logic [7:0] PORT_MAIN  = 8'h00,
  parameter logic [7:0] PORT_EXTRA = 8'h10,
  parameter logic [7:0] PORT_CFG   = 8'h0F,
  parameter logic [5:0] CFG_RESET  = 6'h30
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [15:0]                    cpu_addr,
  input  logic                           cpu_rd,
  input  logic                           cpu_wr,
  input  logic [15:0]                    io_addr,
  input  logic                           io_wr,
  input  logic [7:0]                     io_wdata,
  output logic                           rom_sel,
  output logic [ROM_PAGE_W+14:0]         rom_addr,
  output logic [RAM_PAGE_W+13:0]         ram_addr,
  output logic                           rom_rd,
  output logic                           ram_rd,
  output logic                           ram_we,
  output logic                           spd_base,
  output logic                           spd_double
);
  localparam int WIN_W  = 14;
  localparam int RAM_AW = RAM_PAGE_W + WIN_W;
  localparam int ROM_AW = ROM_PAGE_W + WIN_W + 1;

  logic [7:0] main_pg, extra_pg;
  logic [5:0] cfg_q;

  wire [7:0] port = io_addr[7:0];
  logic unused_bits;
  assign unused_bits = ^{io_addr[15:8], cfg_q[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_pg  <= '0;
      extra_pg <= '0;
      cfg_q    <= CFG_RESET;
    end else if (io_wr) begin
      if (port == PORT_MAIN)  main_pg  <= io_wdata;
      if (port == PORT_EXTRA) extra_pg <= io_wdata;
      if (port == PORT_CFG)   cfg_q    <= io_wdata[5:0];
    end
  end

  wire no_rom  = cfg_q[0];
  wire low_ro  = cfg_q[1];
  wire exp_pg  = cfg_q[3];
  wire [1:0] quad = cpu_addr[15:14];

  logic [RAM_PAGE_W-1:0] pg_lo_win, pg_hi_win, ram_pg;

  assign pg_lo_win = RAM_PAGE_W'({main_pg, exp_pg ? main_pg[7] : 1'b0});
  assign pg_hi_win = exp_pg ? RAM_PAGE_W'({extra_pg, extra_pg[7]})
                            : RAM_PAGE_W'({main_pg, 1'b1});

  always_comb begin
    unique case (quad)
      2'd0:    ram_pg = '0;
      2'd1:    ram_pg = RAM_PAGE_W'(1);
      2'd2:    ram_pg = pg_lo_win;
      default: ram_pg = pg_hi_win;
    endcase
  end

  assign rom_sel  = !no_rom && (quad != 2'd1);
  assign ram_addr = RAM_AW'({ram_pg, cpu_addr[WIN_W-1:0]});
  assign rom_addr = (quad == 2'd0) ? ROM_AW'(cpu_addr[WIN_W-1:0])
                                   : ROM_AW'({ROM_PAGE_W'(main_pg), cpu_addr[14:0]});

  wire low_locked = no_rom && low_ro && (quad == 2'd0);

  assign rom_rd     = cpu_rd && rom_sel;
  assign ram_rd     = cpu_rd && !rom_sel;
  assign ram_we     = cpu_wr && !rom_sel && !low_locked;
  assign spd_base   = cfg_q[5];
  assign spd_double = !cfg_q[4];
endmodule

module bank_window_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [7:0]  io_port,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic        rom_sel,
  input logic [18:0] rom_addr,
  input logic        ram_we,
  input logic        spd_base,
  input logic        spd_double,
  input logic [5:0]  cfg_q,
  input logic [7:0]  main_pg
);
  p_rom_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> !ram_we);

  p_low_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0] && cfg_q[1] && cpu_addr[15:14] == 2'd0) |-> !ram_we);

  p_low_rom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && cpu_addr[15:14] == 2'd0) |-> (rom_sel && rom_addr[18:14] == 5'd0));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_port == 8'h0F) |=> $stable(cfg_q));

  p_main_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 8'h00) |=> main_pg == $past(io_wdata));

  p_speed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 8'h0F) |=> (spd_base == $past(io_wdata[5]) && spd_double == !$past(io_wdata[4])));

  p_write_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> !ram_we);
endmodule

bind bank_window_mapper bank_window_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .io_port(io_addr[7:0]), .io_wr(io_wr), .io_wdata(io_wdata),
  .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_we(ram_we),
  .spd_base(spd_base), .spd_double(spd_double), .cfg_q(cfg_q), .main_pg(main_pg)
);

// File: tb/bank_window_mapper_test.sv
module bank_window_mapper_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0, io_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0, io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic rom_sel, rom_rd, ram_rd, ram_we, spd_base, spd_double;
  logic [18:0] rom_addr;
  logic [21:0] ram_addr;

  always #2 clk = ~clk;

  bank_window_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .rom_rd(rom_rd), .ram_rd(ram_rd), .ram_we(ram_we),
    .spd_base(spd_base), .spd_double(spd_double)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_main, m_extra;
  logic [5:0] m_cfg;

  function automatic logic [7:0] pg(input logic [7:0] r, input logic b);
    return {r[6:0], b};
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    if (a[7:0] == 8'h00) m_main = d;
    if (a[7:0] == 8'h10) m_extra = d;
    if (a[7:0] == 8'h0F) m_cfg = d[5:0];
  endtask

  task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h (addr %h cfg %h)", tag, what, act, exp, cpu_addr, m_cfg);
  endtask

  task automatic probe(input logic [15:0] a, input logic rd, input logic wr);
    logic e_rom, e_we;
    logic [18:0] e_rom_a;
    logic [21:0] e_ram_a;
    logic [7:0] e_pg;
    string tag;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #1;
    e_rom = !m_cfg[0] && a[15:14] != 2'd1;
    e_rom_a = 0; e_pg = 0;
    case (a[15:14])
      2'd0: begin tag = m_cfg[0] ? "R5" : "R2"; e_rom_a = {5'd0, a[13:0]}; e_pg = 0; end
      2'd1: begin tag = "R3"; e_pg = 8'd1; end
      2'd2: begin
        tag = m_cfg[0] ? (m_cfg[3] ? "R7" : "R6") : "R4";
        e_rom_a = {m_main[3:0], a[14:0]};
        e_pg = pg(m_main, m_cfg[3] ? m_main[7] : 1'b0);
      end
      default: begin
        tag = m_cfg[0] ? (m_cfg[3] ? "R7" : "R6") : "R4";
        e_rom_a = {m_main[3:0], a[14:0]};
        e_pg = m_cfg[3] ? pg(m_extra, m_extra[7]) : pg(m_main, 1'b1);
      end
    endcase
    e_ram_a = {e_pg, a[13:0]};
    e_we = wr && !e_rom && !(m_cfg[0] && m_cfg[1] && a[15:14] == 2'd0);
    checks++;
    if (rom_sel !== e_rom) fail_line(tag, "rom_sel", rom_sel, e_rom);
    else if (e_rom && rom_addr !== e_rom_a) fail_line(tag, "rom_addr", rom_addr, e_rom_a);
    else if (!e_rom && ram_addr !== e_ram_a) fail_line(tag, "ram_addr", ram_addr, e_ram_a);
    else if (ram_we !== e_we) fail_line((m_cfg[1] && a[15:14] == 0) ? "R9" : "R8", "ram_we", ram_we, e_we);
    else if (rom_rd !== (rd && e_rom) || ram_rd !== (rd && !e_rom))
      fail_line("R8", "rd strobes", {rom_rd, ram_rd}, {rd && e_rom, rd && !e_rom});
    else if (spd_base !== m_cfg[5] || spd_double !== !m_cfg[4])
      fail_line("R11", "speed", {spd_base, spd_double}, {m_cfg[5], !m_cfg[4]});
    @(negedge clk);
  endtask

  task automatic edges(input logic wr);
    probe(16'h0000, !wr, wr); probe(16'h3FFF, !wr, wr);
    probe(16'h4000, !wr, wr); probe(16'h7FFF, !wr, wr);
    probe(16'h8000, !wr, wr); probe(16'hBFFF, !wr, wr);
    probe(16'hC000, !wr, wr); probe(16'hFFFF, !wr, wr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_main = 0; m_extra = 0; m_cfg = 6'h30;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    probe(16'h0000, 1, 1);
    edges(0); edges(1);
    // R4: ROM page wrap modulo 16
    io_write(16'h0000, 8'h13); edges(0);
    io_write(16'h0000, 8'hFA); probe(16'h8123, 1, 0);
    // R9 ignored in ROM mode
    io_write(16'h000F, 8'h02); edges(1);
    // R5 R6: ROM excluded, fixed pairing
    io_write(16'h000F, 8'h31); io_write(16'h0000, 8'hC5); edges(0); edges(1);
    // R9: protected low RAM
    io_write(16'h000F, 8'h33); edges(1); probe(16'h2ABC, 1, 0);
    // R7: expanded paging, MSB folds into LSB, R12 upper byte aliasing
    io_write(16'h770F, 8'hF9); io_write(16'hAB10, 8'h81); io_write(16'h5500, 8'h7E);
    edges(0); edges(1);
    io_write(16'h0010, 8'h00); io_write(16'h0000, 8'h80); edges(1);
    // R10: other ports ignored
    io_write(16'h0001, 8'hFF); io_write(16'h0011, 8'hFF); io_write(16'h00F0, 8'hFF);
    edges(0);
    // R11: speed encodings
    io_write(16'h000F, 8'h00); probe(16'h4000, 1, 0);
    io_write(16'h000F, 8'hE0); probe(16'h4000, 1, 0);
    io_write(16'h000F, 8'h10); probe(16'h4000, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [7:0] lo;
        case ($urandom_range(0, 3))
          0: lo = 8'h00; 1: lo = 8'h10; 2: lo = 8'h0F; default: lo = 8'($urandom);
        endcase
        io_write({8'($urandom), lo}, 8'($urandom));
      end
      probe(16'($urandom), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule